// File: doc/BRIEF.md
# Complex Conjugate Multiply-Accumulate Lane

This block is a multi-lane fixed-point complex arithmetic datapath. Each beat presents `LANES` complex A operands and `LANES` complex B operands, plus a count of how many of the lanes carry data. For every active lane the block forms A times the conjugate of B, or the plain product A times B when conjugation is switched off. All of this is done at full precision.

Two output modes are selected at run time. In element-wise mode every product is rounded and saturated to the output format and leaves the block two clock edges after its beat. In reduction mode the products are summed into one wide accumulator per lane with no rounding. The sums are rounded once and emitted only when a beat is marked as the end of a row, and the accumulators then restart from zero. A command-start strobe clears the accumulators. An address generator or memory walker upstream feeds beats at up to one per cycle. The mode selects are held steady for the whole of a command.

Top module: `cmac_lane`

## Requirements
- R1: With `conjMode`=1, lane k computes real = ar·br + ai·bi and imaginary = ai·br − ar·bi on the raw two's complement input codes, giving a product with 2·F_IN fractional bits.
- R2: With `conjMode`=0, lane k computes real = ar·br − ai·bi and imaginary = ai·br + ar·bi.
- R3: In element-wise mode (`reduceMode`=0), a beat with `inValid`=1 that is sampled at rising edge n produces `outValid`=1 and its results after rising edge n+2. One beat is accepted every cycle with no stall, and `outValid` is never raised without a beat two edges earlier.
- R4: Conversion to the output format drops 2·F_IN−OUT_F fractional bits and rounds to nearest, with ties rounded away from zero. It is applied once per result.
- R5: A rounded result outside the signed OUT_W-bit range is clamped to −2^(OUT_W−1) or 2^(OUT_W−1)−1, independently for the real and imaginary parts.
- R6: A lane whose index is greater than or equal to `laneCount` contributes zero. In element-wise mode its output field is 0, and in reduction mode it leaves its accumulator unchanged.
- R7: In reduction mode, beats add their products into per-lane accumulators of ACC_W bits. No output appears until a beat with `rowEnd`=1. That beat's results appear two edges later as the rounded sums including that beat, and the next row starts from zero.
- R8: A `startCmd` pulse clears every accumulator. A beat presented in the same cycle as `startCmd` is added to the cleared accumulators.
- R9: After reset, `outValid` is 0 and both result buses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Beat present this cycle |
| startCmd | input | 1 | Command start; clears accumulators |
| rowEnd | input | 1 | Marks the last beat of a row (reduction mode) |
| reduceMode | input | 1 | 1 = accumulate, 0 = element-wise |
| conjMode | input | 1 | 1 = conjugate B, 0 = plain product |
| laneCount | input | $clog2(LANES+1) | Number of active lanes in this beat |
| aRe | input | LANES·IN_W | A real parts, lane k at bits [k·IN_W +: IN_W] |
| aIm | input | LANES·IN_W | A imaginary parts, same packing |
| bRe | input | LANES·IN_W | B real parts, same packing |
| bIm | input | LANES·IN_W | B imaginary parts, same packing |
| outValid | output | 1 | Result lane valid |
| outRe | output | LANES·OUT_W | Result real parts, lane k at bits [k·OUT_W +: OUT_W] |
| outIm | output | LANES·OUT_W | Result imaginary parts, same packing |

## Verification
The hardest situation to reach is the combination of events around the accumulators. These include a start pulse that lands in the same cycle as a beat, a row end that follows back-to-back beats while the previous row's dump is still leaving the pipeline, and row sums large enough to reach saturation. The stimulus runs long back-to-back rows of varying length with shifting lane counts from a deterministic generator. It mixes in idle gaps, stand-alone start pulses in the middle of a row, and a start merged with the first beat. A reference sum kept in the bench tracks every one of these cases. The arithmetic itself is swept over every pair of real codes in both conjugation modes, so the rounding ties and the clamping are all covered.

// File: rtl/cmac_pkg.sv
package cmac_pkg;

  // Strobes the control stage hands to the arithmetic stage, aligned with
  // the registered products.
  typedef struct packed {
    logic accClear;  // zero the accumulators before this cycle's add
    logic accAdd;    // add the registered products into the accumulators
    logic dump;      // emit the rounded sums and restart the row
    logic passOut;   // emit the rounded products directly
  } cmacCtl_t;

endpackage

// File: rtl/cmac_ctrl.sv
module cmac_ctrl
  import cmac_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     startCmd,
  input  logic     rowEnd,
  input  logic     reduceMode,
  output cmacCtl_t ctl,
  output logic     outValid
);

  logic validS1, startS1, rowEndS1, reduceS1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validS1  <= 1'b0;
      startS1  <= 1'b0;
      rowEndS1 <= 1'b0;
      reduceS1 <= 1'b0;
    end else begin
      validS1  <= inValid;
      startS1  <= startCmd;
      rowEndS1 <= rowEnd & inValid;
      reduceS1 <= reduceMode;
    end
  end

  always_comb begin
    ctl.accClear = startS1;
    ctl.accAdd   = validS1 & reduceS1;
    ctl.dump     = validS1 & reduceS1 & rowEndS1;
    ctl.passOut  = validS1 & ~reduceS1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= ctl.dump | ctl.passOut;
  end

endmodule

// File: rtl/cmac_datapath.sv
module cmac_datapath
  import cmac_pkg::*;
#(
  parameter int LANES = 2,
  parameter int IN_W  = 6,
  parameter int F_IN  = 3,
  parameter int OUT_W = 6,
  parameter int OUT_F = 3,
  parameter int ACC_W = 20,
  parameter int CNT_W = $clog2(LANES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic                   conjMode,
  input  logic [CNT_W-1:0]       laneCount,
  input  logic [LANES*IN_W-1:0]  aRe,
  input  logic [LANES*IN_W-1:0]  aIm,
  input  logic [LANES*IN_W-1:0]  bRe,
  input  logic [LANES*IN_W-1:0]  bIm,
  input  cmacCtl_t               ctl,
  output logic [LANES*OUT_W-1:0] outRe,
  output logic [LANES*OUT_W-1:0] outIm
);

  localparam int PROD_W = 2 * IN_W + 1;
  localparam int SHIFT  = 2 * F_IN - OUT_F;
  localparam int EXT_W  = ACC_W + 1;
  localparam logic signed [EXT_W-1:0] HALF = EXT_W'(1) <<< (SHIFT - 1);
  localparam logic signed [EXT_W-1:0] OMAX = (EXT_W'(1) <<< (OUT_W - 1)) - EXT_W'(1);
  localparam logic signed [EXT_W-1:0] OMIN = -(EXT_W'(1) <<< (OUT_W - 1));

  // Single rounding point: nearest, ties away from zero, then clamp.
  function automatic logic signed [OUT_W-1:0] requant(input logic signed [ACC_W-1:0] v);
    logic signed [EXT_W-1:0] mag, r;
    logic neg;
    neg = v[ACC_W-1];
    mag = neg ? -EXT_W'(v) : EXT_W'(v);
    r   = (mag + HALF) >>> SHIFT;
    if (neg) r = -r;
    if (r > OMAX) r = OMAX;
    if (r < OMIN) r = OMIN;
    return r[OUT_W-1:0];
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic signed [IN_W-1:0]   ar, ai, br, bi;
    logic signed [PROD_W-1:0] rr, ii, ir, ri, pRe, pIm;
    logic signed [PROD_W-1:0] prodRe, prodIm;
    logic signed [ACC_W-1:0]  accRe, accIm, baseRe, baseIm, sumRe, sumIm;
    logic signed [OUT_W-1:0]  resRe, resIm;
    logic                     laneOn;

    assign ar = aRe[g*IN_W +: IN_W];
    assign ai = aIm[g*IN_W +: IN_W];
    assign br = bRe[g*IN_W +: IN_W];
    assign bi = bIm[g*IN_W +: IN_W];

    assign rr = PROD_W'(ar) * PROD_W'(br);
    assign ii = PROD_W'(ai) * PROD_W'(bi);
    assign ir = PROD_W'(ai) * PROD_W'(br);
    assign ri = PROD_W'(ar) * PROD_W'(bi);

    assign pRe    = conjMode ? (rr + ii) : (rr - ii);
    assign pIm    = conjMode ? (ir - ri) : (ir + ri);
    assign laneOn = CNT_W'(g) < laneCount;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        prodRe <= '0;
        prodIm <= '0;
      end else if (inValid) begin
        prodRe <= laneOn ? pRe : '0;
        prodIm <= laneOn ? pIm : '0;
      end
    end

    assign baseRe = ctl.accClear ? '0 : accRe;
    assign baseIm = ctl.accClear ? '0 : accIm;
    assign sumRe  = baseRe + ACC_W'(prodRe);
    assign sumIm  = baseIm + ACC_W'(prodIm);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        accRe <= '0;
        accIm <= '0;
        resRe <= '0;
        resIm <= '0;
      end else begin
        if (ctl.accAdd) begin
          accRe <= ctl.dump ? '0 : sumRe;
          accIm <= ctl.dump ? '0 : sumIm;
        end else if (ctl.accClear) begin
          accRe <= '0;
          accIm <= '0;
        end
        if (ctl.passOut) begin
          resRe <= requant(ACC_W'(prodRe));
          resIm <= requant(ACC_W'(prodIm));
        end else if (ctl.dump) begin
          resRe <= requant(sumRe);
          resIm <= requant(sumIm);
        end
      end
    end

    assign outRe[g*OUT_W +: OUT_W] = resRe;
    assign outIm[g*OUT_W +: OUT_W] = resIm;

    assert_mask_lane_R6: assert property (@(posedge clk) disable iff (!rstN)
      ($past(inValid) && ($past(laneCount) <= CNT_W'(g))) |-> (prodRe == '0 && prodIm == '0));

    assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
      $past(ctl.accClear && !ctl.accAdd) |-> (accRe == '0 && accIm == '0));

    assert_row_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
      $past(ctl.dump) |-> (accRe == '0 && accIm == '0));
  end

endmodule

// File: rtl/cmac_lane.sv
module cmac_lane
  import cmac_pkg::*;
#(
  parameter int LANES = 2,
  parameter int IN_W  = 6,
  parameter int F_IN  = 3,
  parameter int OUT_W = 6,
  parameter int OUT_F = 3,
  parameter int ACC_W = 20,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic                   startCmd,
  input  logic                   rowEnd,
  input  logic                   reduceMode,
  input  logic                   conjMode,
  input  logic [CNT_W-1:0]       laneCount,
  input  logic [LANES*IN_W-1:0]  aRe,
  input  logic [LANES*IN_W-1:0]  aIm,
  input  logic [LANES*IN_W-1:0]  bRe,
  input  logic [LANES*IN_W-1:0]  bIm,
  output logic                   outValid,
  output logic [LANES*OUT_W-1:0] outRe,
  output logic [LANES*OUT_W-1:0] outIm
);

  cmacCtl_t ctl;

  cmac_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .startCmd   (startCmd),
    .rowEnd     (rowEnd),
    .reduceMode (reduceMode),
    .ctl        (ctl),
    .outValid   (outValid)
  );

  cmac_datapath #(
    .LANES (LANES), .IN_W (IN_W), .F_IN (F_IN),
    .OUT_W (OUT_W), .OUT_F (OUT_F), .ACC_W (ACC_W), .CNT_W (CNT_W)
  ) datapath_i (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .conjMode  (conjMode),
    .laneCount (laneCount),
    .aRe       (aRe),
    .aIm       (aIm),
    .bRe       (bRe),
    .bIm       (bIm),
    .ctl       (ctl),
    .outRe     (outRe),
    .outIm     (outIm)
  );

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inValid, 2) && !$past(reduceMode, 2)) |-> outValid);

  assert_valid_source_R3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid, 2));

  assert_no_early_dump_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inValid, 2) && $past(reduceMode, 2) && !$past(rowEnd, 2)) |-> !outValid);

endmodule

// File: tb/cmac_lane_tb.sv
module cmac_lane_tb_top;

  localparam int LANES = 2;
  localparam int IN_W  = 6;
  localparam int F_IN  = 3;
  localparam int OUT_W = 6;
  localparam int OUT_F = 3;
  localparam int ACC_W = 20;
  localparam int CNT_W = $clog2(LANES + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, startCmd = 1'b0, rowEnd = 1'b0;
  logic reduceMode = 1'b0, conjMode = 1'b1;
  logic [CNT_W-1:0] laneCount = '0;
  logic [LANES*IN_W-1:0] aRe = '0, aIm = '0, bRe = '0, bIm = '0;
  logic outValid;
  logic [LANES*OUT_W-1:0] outRe, outIm;

  always #10 clk = ~clk;

  cmac_lane #(
    .LANES (LANES), .IN_W (IN_W), .F_IN (F_IN),
    .OUT_W (OUT_W), .OUT_F (OUT_F), .ACC_W (ACC_W)
  ) dut_i (
    .clk (clk), .rstN (rstN), .inValid (inValid), .startCmd (startCmd),
    .rowEnd (rowEnd), .reduceMode (reduceMode), .conjMode (conjMode),
    .laneCount (laneCount), .aRe (aRe), .aIm (aIm), .bRe (bRe), .bIm (bIm),
    .outValid (outValid), .outRe (outRe), .outIm (outIm)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;
  int xar[LANES], xai[LANES], xbr[LANES], xbi[LANES];
  longint accR[LANES], accI[LANES];
  logic [LANES*OUT_W-1:0] qRe[$], qIm[$];
  int qDue[$];
  string qTag[$];
  int seed = 32'h1234_5678;

  function automatic int wrapIn(int x);
    return ((x % 64) + 64) % 64 - 32;
  endfunction

  function automatic int nextVal();
    seed = seed * 1664525 + 1013904223;
    return wrapIn(seed >>> 16);
  endfunction

  function automatic int rq(longint v);
    int sh = 2 * F_IN - OUT_F;
    longint half = longint'(1) <<< (sh - 1);
    longint r;
    if (v >= 0) r = (v + half) >>> sh;
    else        r = -((-v + half) >>> sh);
    if (r > (1 <<< (OUT_W - 1)) - 1) r = (1 <<< (OUT_W - 1)) - 1;
    if (r < -(1 <<< (OUT_W - 1)))    r = -(1 <<< (OUT_W - 1));
    return int'(r);
  endfunction

  task automatic check(input string tag, input logic [LANES*OUT_W-1:0] gotR,
                       input logic [LANES*OUT_W-1:0] gotI,
                       input logic [LANES*OUT_W-1:0] expR,
                       input logic [LANES*OUT_W-1:0] expI);
    checks++;
    if (gotR !== expR || gotI !== expI) begin
      fails++;
      $display("FAIL %s cycle %0d: got re=%h im=%h expected re=%h im=%h",
               tag, cyc, gotR, gotI, expR, expI);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    #2;
    cyc++;
    if (qDue.size() > 0 && qDue[0] == cyc) begin
      if (!outValid) begin
        checks++; fails++;
        $display("FAIL %s (R3) cycle %0d: outValid got 0 expected 1", qTag[0], cyc);
      end else begin
        check(qTag[0], outRe, outIm, qRe[0], qIm[0]);
      end
      void'(qDue.pop_front()); void'(qRe.pop_front());
      void'(qIm.pop_front()); void'(qTag.pop_front());
    end else if (outValid) begin
      checks++; fails++;
      $display("FAIL R3/R7 cycle %0d: outValid got 1 expected 0", cyc);
    end
  endtask

  task automatic idle(input int n);
    inValid = 1'b0; startCmd = 1'b0; rowEnd = 1'b0;
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic startOnly();
    inValid = 1'b0; startCmd = 1'b1; rowEnd = 1'b0;
    for (int k = 0; k < LANES; k++) begin accR[k] = 0; accI[k] = 0; end
    cycle();
    startCmd = 1'b0;
  endtask

  // Present one beat from xar/xai/xbr/xbi and record what must come out.
  task automatic beat(input bit st, input bit re, input int cnt, input string tag);
    logic [LANES*OUT_W-1:0] eR, eI;
    bit emit;
    eR = '0; eI = '0;
    emit = !reduceMode || re;
    if (st) for (int k = 0; k < LANES; k++) begin accR[k] = 0; accI[k] = 0; end
    for (int k = 0; k < LANES; k++) begin
      longint pr, pi;
      aRe[k*IN_W +: IN_W] = IN_W'(xar[k]);
      aIm[k*IN_W +: IN_W] = IN_W'(xai[k]);
      bRe[k*IN_W +: IN_W] = IN_W'(xbr[k]);
      bIm[k*IN_W +: IN_W] = IN_W'(xbi[k]);
      if (conjMode) begin
        pr = xar[k] * xbr[k] + xai[k] * xbi[k];
        pi = xai[k] * xbr[k] - xar[k] * xbi[k];
      end else begin
        pr = xar[k] * xbr[k] - xai[k] * xbi[k];
        pi = xai[k] * xbr[k] + xar[k] * xbi[k];
      end
      if (k >= cnt) begin pr = 0; pi = 0; end
      if (reduceMode) begin
        accR[k] += pr; accI[k] += pi;
        if (re) begin
          eR[k*OUT_W +: OUT_W] = OUT_W'(rq(accR[k]));
          eI[k*OUT_W +: OUT_W] = OUT_W'(rq(accI[k]));
          accR[k] = 0; accI[k] = 0;
        end
      end else begin
        eR[k*OUT_W +: OUT_W] = OUT_W'(rq(pr));
        eI[k*OUT_W +: OUT_W] = OUT_W'(rq(pi));
      end
    end
    laneCount = CNT_W'(cnt);
    inValid = 1'b1; startCmd = st; rowEnd = re;
    if (emit) begin
      qRe.push_back(eR); qIm.push_back(eI); qDue.push_back(cyc + 2); qTag.push_back(tag);
    end
    cycle();
    inValid = 1'b0; startCmd = 1'b0; rowEnd = 1'b0;
  endtask

  task automatic randLanes();
    for (int k = 0; k < LANES; k++) begin
      xar[k] = nextVal(); xai[k] = nextVal(); xbr[k] = nextVal(); xbi[k] = nextVal();
    end
  endtask

  // Element-wise sweep: every (ar, br) pair, other components derived.
  task automatic sweep(input string tag);
    for (int a = -32; a < 32; a++) begin
      for (int b = -32; b < 32; b++) begin
        xar[0] = a;  xbr[0] = b;
        xai[0] = wrapIn(a * 7 + b * 3 + 5);  xbi[0] = wrapIn(a * 5 - b * 11);
        xar[1] = b;  xbr[1] = a;
        xai[1] = wrapIn(b * 13 + 9);         xbi[1] = wrapIn(a * 3 + b);
        beat(1'b0, 1'b0, (a + b + 64) % 3, tag);
      end
    end
    idle(3);
  endtask

  task automatic reduceRows(input int nRows, input string tag);
    for (int r = 0; r < nRows; r++) begin
      int len = r % 5 + 1;
      for (int j = 0; j < len; j++) begin
        randLanes();
        beat(1'b0, j == len - 1, (r + j) % 3, tag);
        if (r % 7 == 3 && j == 0) idle(2);
      end
    end
    idle(3);
  endtask

  initial begin
    idle(4);
    rstN = 1'b1;
    idle(1);
    // R9: reset state
    check("R9", {outValid, outRe}, outIm, '0, '0);

    reduceMode = 1'b0; conjMode = 1'b1;
    sweep("R1/R3/R4/R5/R6 conj element-wise");
    conjMode = 1'b0;
    sweep("R2/R4/R5/R6 plain element-wise");

    conjMode = 1'b1; reduceMode = 1'b1;
    startOnly();
    reduceRows(60, "R7/R4/R5/R6 reduction rows");
    conjMode = 1'b0;
    startOnly();
    reduceRows(30, "R7/R2 reduction rows plain");

    // R8: start in mid-row discards the partial sum
    conjMode = 1'b1;
    randLanes(); beat(1'b0, 1'b0, 2, "R8");
    randLanes(); beat(1'b0, 1'b0, 2, "R8");
    startOnly();
    randLanes(); beat(1'b0, 1'b0, 2, "R8 after start");
    randLanes(); beat(1'b0, 1'b1, 2, "R8 after start");
    idle(2);
    // R8: start merged with a beat counts that beat
    randLanes(); beat(1'b0, 1'b0, 2, "R8");
    randLanes(); beat(1'b1, 1'b0, 2, "R8 start with beat");
    randLanes(); beat(1'b0, 1'b1, 1, "R8 start with beat");
    idle(3);
    // R5: full-scale operands summed until both parts saturate
    for (int k = 0; k < LANES; k++) begin
      xar[k] = -32; xai[k] = 31; xbr[k] = -32; xbi[k] = -32;
    end
    for (int j = 0; j < 8; j++) beat(1'b0, j == 7, 2, "R5 saturated row");
    idle(4);

    if (qDue.size() != 0) begin
      checks++; fails++;
      $display("FAIL R3: %0d results missing, expected 0", qDue.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule